// File: doc/BRIEF.md
# DMA Channel Address Generator with Selectable Reload

This block produces the source and destination byte addresses of a single DMA channel. Each side has an address register that is seeded from an initial address when the channel starts. It then moves by one byte on every beat strobe, up, down or not at all. At a chosen boundary it returns to its initial address. That boundary is never, end of burst, end of block or end of transaction, and each side picks its own.

Both sides are set through one 8-bit control byte. The byte can be written only while the channel is idle. Surrounding logic drives the busy level, the beat strobe and the three boundary strobes. It reads the two current addresses, which the block updates on the clock edge after each strobe.

Top module: `dma_addr_gen`

## Requirements
- R1: While rst_n is low at a clock edge, src_addr, dst_addr and cfg_q become 0.
- R2: The control byte holds source reload in bits 7:6, source direction in bits 5:4, destination reload in bits 3:2 and destination direction in bits 1:0. A write with cfg_we high while busy is low appears on cfg_q after the next edge.
- R3: A control write made while busy is high is discarded. Both cfg_q and the stepping behaviour keep the old setting.
- R4: In the first busy cycle (busy high, low in the previous cycle), each address is loaded with its initial input. Beat and boundary strobes in that same cycle have no effect.
- R5: While busy, a beat changes the address by +1 for direction code 01 and by -1 for code 10, wrapping modulo 2^ADDR_W. It leaves the address unchanged for codes 00 and 11.
- R6: Reload code 00 never restores the initial address.
- R7: Reload code 01 restores the initial address when block_end is high.
- R8: Reload code 10 restores the initial address when burst_end is high.
- R9: Reload code 11 restores the initial address when xact_end is high.
- R10: When the selected boundary strobe and a beat arrive in the same busy cycle, the address takes the initial value and does not step.
- R11: While busy is low, both addresses hold their values whatever the strobes do.
- R12: The source side follows only its own two fields and its own initial address. The destination side follows only its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write value |
| cfg_q | output | 8 | Current control byte |
| busy | input | 1 | Channel active level |
| beat | input | 1 | One byte moved on both sides |
| burst_end | input | 1 | Current burst finishes this cycle |
| block_end | input | 1 | Current block finishes this cycle |
| xact_end | input | 1 | Current transaction finishes this cycle |
| src_init | input | ADDR_W | Initial source address |
| dst_init | input | ADDR_W | Initial destination address |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |

## Verification
Every address register feeds a port directly. A wrong load, step or reload therefore shows on src_addr or dst_addr on the edge right after the strobe that caused it, and it persists until the next reload corrects it. A broken write lock shows on cfg_q one edge after a write made while busy. Beyond that edge, it changes the direction of the next beat. The checks compare each address after every edge across all sixteen reload and direction pairs, so a fault is caught within one cycle of its cause.

// File: rtl/dma_addr_pkg.sv
// Shared types for the DMA address generator.
// Assumes: the control byte layout below is fixed, because software encodes it.
package dma_addr_pkg;

    // Point at which an address returns to its initial value.
    typedef enum logic [1:0] {
        RL_NEVER = 2'b00,
        RL_BLOCK = 2'b01,
        RL_BURST = 2'b10,
        RL_XACT  = 2'b11
    } reload_e;

    // Step applied per beat.
    typedef enum logic [1:0] {
        DIR_HOLD  = 2'b00,
        DIR_UP    = 2'b01,
        DIR_DOWN  = 2'b10,
        DIR_HOLDX = 2'b11
    } step_e;

    // Control byte, most significant field first.
    typedef struct packed {
        reload_e src_rl;
        step_e   src_dir;
        reload_e dst_rl;
        step_e   dst_dir;
    } addr_cfg_t;

    // Boundary strobes presented to each lane.
    typedef struct packed {
        logic burst;
        logic block;
        logic xact;
    } end_ev_t;

endpackage

// File: rtl/dma_addr_cfg.sv
// Control byte register for the address generator.
// Accepts a write only while the channel is idle; a write while busy is lost.
// Assumes: synchronous active-low reset clears every field to its 00 code.
module dma_addr_cfg
    import dma_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       we,
    input  logic [7:0] wdata,
    output addr_cfg_t  cfg
);

    // Capture the control byte on an idle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we && !busy) begin
            cfg <= addr_cfg_t'(wdata);
        end
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg)); // R3

    AST_CFG_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !busy) |=> (cfg == $past(wdata))); // R2

endmodule

// File: rtl/dma_reload_sel.sv
// Picks the boundary strobe that restores an address, from the reload code.
// Purely combinational; code 00 never fires.
module dma_reload_sel
    import dma_addr_pkg::*;
(
    input  reload_e mode,
    input  end_ev_t ev,
    output logic    hit
);

    // Map the reload code onto one boundary strobe.
    always_comb begin
        case (mode)
            RL_BLOCK: hit = ev.block;
            RL_BURST: hit = ev.burst;
            RL_XACT:  hit = ev.xact;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_addr_lane.sv
// One address side (source or destination).
// Loads the initial address on channel start. While busy, it restores that
// value on its selected boundary, and otherwise steps by one byte per beat.
// Assumes: start is high only in the first busy cycle; a reload wins over a step.
module dma_addr_lane
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              start,
    input  logic              beat,
    input  end_ev_t           ev,
    input  reload_e           rl_mode,
    input  step_e             dir,
    input  logic [ADDR_W-1:0] init,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic              hit;
    logic [ADDR_W-1:0] stepped;

    dma_reload_sel u_sel (
        .mode (rl_mode),
        .ev   (ev),
        .hit  (hit)
    );

    // Next address for a beat in the configured direction.
    always_comb begin
        case (dir)
            DIR_UP:   stepped = addr + ONE;
            DIR_DOWN: stepped = addr - ONE;
            default:  stepped = addr;
        endcase
    end

    // Address register: start load, then reload, then step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (start) begin
            addr <= init;
        end else if (busy) begin
            if (hit) begin
                addr <= init;
            end else if (beat) begin
                addr <= stepped;
            end
        end
    end

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (addr == $past(init))); // R4

    AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && hit) |=> (addr == $past(init))); // R10

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && !hit && beat && dir == DIR_UP) |=> (addr == $past(addr) + ONE)); // R5

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && !hit && beat && dir == DIR_DOWN) |=> (addr == $past(addr) - ONE)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(addr)); // R11

endmodule

// File: rtl/dma_addr_gen.sv
// DMA channel address generator, top level.
// Holds the control byte, detects channel start, and runs one lane per side.
// Assumes: all strobes are synchronous to clk and single-cycle.
module dma_addr_gen
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_q,
    input  logic              busy,
    input  logic              beat,
    input  logic              burst_end,
    input  logic              block_end,
    input  logic              xact_end,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);

    localparam int NLANE = 2;
    localparam int SRC   = 0;
    localparam int DST   = 1;

    addr_cfg_t         cfg;
    logic              busy_q;
    logic              start;
    end_ev_t           ev;
    reload_e           rl_a   [NLANE];
    step_e             dir_a  [NLANE];
    logic [ADDR_W-1:0] init_a [NLANE];
    logic [ADDR_W-1:0] addr_a [NLANE];

    dma_addr_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    // Remember the previous busy level to find the first busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else begin
            busy_q <= busy;
        end
    end

    // Start pulse and grouped boundary strobes.
    always_comb begin
        start    = busy && !busy_q;
        ev.burst = burst_end;
        ev.block = block_end;
        ev.xact  = xact_end;
    end

    // Route per-side fields into lane arrays.
    always_comb begin
        rl_a[SRC]   = cfg.src_rl;
        dir_a[SRC]  = cfg.src_dir;
        init_a[SRC] = src_init;
        rl_a[DST]   = cfg.dst_rl;
        dir_a[DST]  = cfg.dst_dir;
        init_a[DST] = dst_init;
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        dma_addr_lane #(.ADDR_W(ADDR_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .busy    (busy),
            .start   (start),
            .beat    (beat),
            .ev      (ev),
            .rl_mode (rl_a[g]),
            .dir     (dir_a[g]),
            .init    (init_a[g]),
            .addr    (addr_a[g])
        );
    end

    assign cfg_q    = cfg;
    assign src_addr = addr_a[SRC];
    assign dst_addr = addr_a[DST];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (src_addr == '0 && dst_addr == '0 && cfg_q == 8'h00)); // R1

endmodule

// File: tb/sim_dma_addr_gen.sv
`timescale 1ns/1ps
module sim_dma_addr_gen;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [7:0]    cfg_wdata;
    logic [7:0]    cfg_q;
    logic          busy, beat, burst_end, block_end, xact_end;
    logic [AW-1:0] src_init, dst_init, src_addr, dst_addr;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    dma_addr_gen #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .busy(busy), .beat(beat), .burst_end(burst_end),
        .block_end(block_end), .xact_end(xact_end), .src_init(src_init),
        .dst_init(dst_init), .src_addr(src_addr), .dst_addr(dst_addr)
    );

    // Vector: {busy, beat, burst_end, block_end, xact_end, exp_src, exp_dst}
    // Control 0x96: source reload at burst, up; destination reload at block, down.
    localparam int NV = 10;
    localparam logic [36:0] VEC [NV] = '{
        {5'b10000, 16'h0100, 16'h0200},
        {5'b11000, 16'h0101, 16'h01FF},
        {5'b11000, 16'h0102, 16'h01FE},
        {5'b11100, 16'h0100, 16'h01FD},
        {5'b11000, 16'h0101, 16'h01FC},
        {5'b11010, 16'h0102, 16'h0200},
        {5'b11000, 16'h0103, 16'h01FF},
        {5'b10000, 16'h0103, 16'h01FF},
        {5'b11001, 16'h0104, 16'h01FE},
        {5'b01000, 16'h0104, 16'h01FE}
    };

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Model of one side, written from R5 to R10.
    function automatic logic [AW-1:0] predict(input logic [AW-1:0] cur, input logic [AW-1:0] ini,
                                              input logic [1:0] rl, input logic [1:0] dr,
                                              input logic bt, input logic bu, input logic bk,
                                              input logic xa);
        logic h;
        h = (rl == 2'b01) ? bk : (rl == 2'b10) ? bu : (rl == 2'b11) ? xa : 1'b0;
        if (h) return ini;
        if (bt && dr == 2'b01) return cur + 16'd1;
        if (bt && dr == 2'b10) return cur - 16'd1;
        return cur;
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_wdata = 8'h00; busy = 0; beat = 0;
        burst_end = 0; block_end = 0; xact_end = 0;
        src_init = 16'h0100; dst_init = 16'h0200;
        tick(); tick();
        // R1: reset state
        chk("R1 src", src_addr, '0);
        chk("R1 dst", dst_addr, '0);
        chk("R1 cfg", {8'h00, cfg_q}, 16'h0000);
        rst_n = 1;

        // R2: idle write of the control byte
        cfg_we = 1; cfg_wdata = 8'h96;
        tick();
        cfg_we = 0;
        chk("R2 cfg", {8'h00, cfg_q}, 16'h0096);

        // Vector walk: R4 R5 R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            {busy, beat, burst_end, block_end, xact_end} = VEC[i][36:32];
            tick();
            chk($sformatf("R8/R5 vec%0d src", i), src_addr, VEC[i][31:16]);
            chk($sformatf("R7/R5 vec%0d dst", i), dst_addr, VEC[i][15:0]);
        end
        beat = 0;

        // R3: write while busy is discarded
        busy = 1;
        tick();
        chk("R4 start src", src_addr, 16'h0100);
        cfg_we = 1; cfg_wdata = 8'h00; beat = 1;
        tick();
        cfg_we = 0; beat = 0;
        chk("R3 cfg kept", {8'h00, cfg_q}, 16'h0096);
        chk("R3 src still up", src_addr, 16'h0101);
        chk("R3 dst still down", dst_addr, 16'h01FF);

        // R5: wrap at both ends
        busy = 0;
        tick();
        cfg_we = 1; cfg_wdata = 8'b00_10_00_01;
        src_init = 16'h0000; dst_init = 16'hFFFF;
        tick();
        cfg_we = 0;
        chk("R2 cfg fields", {8'h00, cfg_q}, 16'h0021);
        busy = 1; beat = 1;
        tick();
        chk("R4 beat ignored src", src_addr, 16'h0000);
        chk("R4 beat ignored dst", dst_addr, 16'hFFFF);
        tick();
        chk("R5 wrap down src", src_addr, 16'hFFFF);
        chk("R5 wrap up dst", dst_addr, 16'h0000);
        busy = 0; beat = 0;
        tick();

        // All reload and direction pairs: R5 R6 R7 R8 R9 R10 R12
        for (int c = 0; c < 16; c++) begin
            logic [1:0] srl, sdr, drl, ddr;
            logic [AW-1:0] es, ed;
            srl = c[3:2]; sdr = c[1:0]; drl = ~c[3:2]; ddr = ~c[1:0];
            busy = 0; beat = 0; burst_end = 0; block_end = 0; xact_end = 0;
            cfg_we = 1; cfg_wdata = {srl, sdr, drl, ddr};
            src_init = 16'h4000 + 16'(c * 16'h0111); dst_init = 16'h8000 - 16'(c * 16'h0023);
            tick();
            cfg_we = 0;
            busy = 1; beat = 1; burst_end = 1; block_end = 1; xact_end = 1;
            tick();
            es = src_init; ed = dst_init;
            chk($sformatf("R4 c%0d src", c), src_addr, es);
            chk($sformatf("R4 c%0d dst", c), dst_addr, ed);
            for (int k = 1; k <= 12; k++) begin
                beat = (k % 4) != 0; burst_end = (k % 3) == 0;
                block_end = (k % 6) == 0; xact_end = (k == 11);
                es = predict(es, src_init, srl, sdr, beat, burst_end, block_end, xact_end);
                ed = predict(ed, dst_init, drl, ddr, beat, burst_end, block_end, xact_end);
                tick();
                chk($sformatf("R12 c%0d k%0d src rl=%0d", c, k, srl), src_addr, es);
                chk($sformatf("R12 c%0d k%0d dst rl=%0d", c, k, drl), dst_addr, ed);
            end
            // R11: idle with strobes active holds
            busy = 0; beat = 1; burst_end = 1; block_end = 1; xact_end = 1;
            tick();
            chk($sformatf("R11 c%0d src", c), src_addr, es);
            chk($sformatf("R11 c%0d dst", c), dst_addr, ed);
        end
        beat = 0; burst_end = 0; block_end = 0; xact_end = 0;

        // R6: never-reload ignores every boundary
        cfg_we = 1; cfg_wdata = 8'b00_01_00_00;
        src_init = 16'h0010; dst_init = 16'h0020;
        tick();
        cfg_we = 0; busy = 1;
        tick();
        beat = 1; burst_end = 1; block_end = 1; xact_end = 1;
        tick();
        chk("R6 src no reload", src_addr, 16'h0011);
        chk("R6 dst fixed", dst_addr, 16'h0020);
        busy = 0; beat = 0; burst_end = 0; block_end = 0; xact_end = 0;
        tick();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule